// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This block is a small 32-bit processor that finishes every instruction in the clock cycle that fetches it. It runs nine instructions: word load, word store, add, subtract, AND, OR, signed set-less-than, branch-if-equal and jump. The core holds a program counter, a 32-entry register file, one ALU, and two separate word memories: one for instructions and one for data. Fetch and a load or store therefore never compete for a memory port.

Within one cycle the instruction word is read at the program counter and decoded into control. The source registers are read and the ALU works on a register or a sign-extended immediate. A load reads the data memory. At the rising edge the result is written back and the program counter moves on. A preload port fills either memory before or while the core runs. Three observation buses show the current program counter, the register write of the current instruction and the store of the current instruction.

Top module: `sc_core`

## Requirements
- R1: At a rising edge with rst_n low, the program counter becomes 0 and every register becomes 0. The first instruction after reset is fetched from instruction word 0.
- R2: Each instruction completes in one cycle. While pc_o shows an instruction's address, wb_* and st_* describe that instruction. Its register and memory effects are visible to the instruction in the next cycle.
- R3: A register-format word (bits [31:26] = 0x00) reads registers rs [25:21] and rt [20:16] and writes register rd [15:11]. The funct field [5:0] selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 if rs < rt, else 0). The next PC is PC+4.
- R4: A load (opcode 0x23) forms the address rs + sign-extended imm [15:0]. It writes the data word at that address into register rt.
- R5: A store (opcode 0x2B) writes register rt to the data word at rs + sign-extended imm. st_addr and st_data report the byte address and the value. wb_en stays low and the next PC is PC+4.
- R6: Register 0 always reads as zero. An instruction whose destination is register 0 changes no register and keeps wb_en low.
- R7: Branch-if-equal (opcode 0x04) compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended imm shifted left by two, and negative offsets branch backward. Otherwise the next PC is PC+4. It writes nothing.
- R8: Jump (opcode 0x02) loads the PC with bits [31:28] of PC+4, followed by the 26-bit index [25:0], followed by two zero bits. It writes nothing.
- R9: Any other opcode, and any register-format word with an unlisted funct or with nonzero bits [10:6], writes nothing and advances the PC by 4.
- R10: At a rising edge with pre_we high, pre_data is written to word pre_addr. The target is data memory when pre_dmem is 1 and instruction memory when it is 0. Memory contents are not cleared by reset.
- R11: The two memories are independent: a store never changes an instruction word at the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_we | input | 1 | Preload write strobe |
| pre_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| pre_addr | input | PRE_AW | Preload word index |
| pre_data | input | 32 | Preload word value |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en | output | 1 | This instruction writes a register |
| wb_idx | output | 5 | Destination register number |
| wb_data | output | 32 | Value being written back |
| st_en | output | 1 | This instruction stores to data memory |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store value |

## Verification
Three outcomes are the hardest to reach from the ports. The first is a backward branch that is finally not taken. The second is a store that must not leak into the instruction memory. The third is a register file that must really clear on reset. The program runs a counting loop closed by a negative branch offset, and the exit is reached only when a sum matches an earlier result. It stores into the data word whose index is the halt instruction's own index: a shared memory would turn the halt into a no-op and move the PC. It then runs a second time after a fresh reset. Its first instruction ORs two registers that the previous run left nonzero, and it must yield zero.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the single-cycle core: instruction field codes,
// ALU operation encoding and the decoded control bundle.
// Assumes the fixed 32-bit instruction format with 6-bit opcode/funct.
package sc_core_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    // Primary opcodes
    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    // Register-format function codes
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    // What the main decoder asks of the ALU control stage
    typedef enum logic [1:0] {
        CLS_ADDR,
        CLS_CMP,
        CLS_FUNCT,
        CLS_NONE
    } alu_cls_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    mem_write;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// Combinational ALU for the core: add, subtract, AND, OR and signed
// set-less-than. Also flags a zero result for the equality branch.
// Assumes operands are two's complement words of width W.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] diff;

    assign diff = a - b;

    // Select the result of the requested operation
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    // Equality flag taken from the subtract path
    assign zero = (diff == '0);
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// Register file: two combinational read ports and one write port that
// writes on the rising edge. Entry 0 is a constant zero and has no storage.
// Synchronous active-low reset clears every stored entry.
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign q[i] = '0;
        end else begin : g_store
            logic [W-1:0] r;
            // Hold one register, load it when addressed
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r <= '0;
                else if (we && (waddr == AW'(i)))
                    r <= wdata;
            end
            assign q[i] = r;
        end
    end

    assign rd1 = q[ra1];
    assign rd2 = q[ra2];
endmodule

// File: rtl/sc_wordmem.sv
`timescale 1ns/1ps
// Word-wide memory with asynchronous read, one run-time write port and a
// preload write port. The preload port wins when both write in the same
// cycle. Contents are not reset.
module sc_wordmem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_idx,
    input  logic [W-1:0]  pre_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [WORDS];

    // Apply a preload or run-time write
    always_ff @(posedge clk) begin
        if (pre_we)
            mem[pre_idx] <= pre_data;
        else if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// Control decode in two levels: the main decoder maps the opcode to
// datapath selects and an ALU class; the ALU control stage maps the class
// and funct to an operation. Unsupported words decode to a no-op.
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    output ctrl_t      ctrl
);
    logic     m_reg_wr, m_dst_rd, m_b_imm, m_from_mem, m_mem_wr, m_branch, m_jump;
    alu_cls_e cls;
    alu_op_e  op;
    logic     fn_ok;

    // Main decoder: opcode to datapath selects
    always_comb begin
        m_reg_wr   = 1'b0;
        m_dst_rd   = 1'b0;
        m_b_imm    = 1'b0;
        m_from_mem = 1'b0;
        m_mem_wr   = 1'b0;
        m_branch   = 1'b0;
        m_jump     = 1'b0;
        cls        = CLS_NONE;
        case (opcode)
            OPC_REG: begin
                m_reg_wr = 1'b1;
                m_dst_rd = 1'b1;
                cls      = CLS_FUNCT;
            end
            OPC_LOAD: begin
                m_reg_wr   = 1'b1;
                m_b_imm    = 1'b1;
                m_from_mem = 1'b1;
                cls        = CLS_ADDR;
            end
            OPC_STORE: begin
                m_b_imm  = 1'b1;
                m_mem_wr = 1'b1;
                cls      = CLS_ADDR;
            end
            OPC_BEQ: begin
                m_branch = 1'b1;
                cls      = CLS_CMP;
            end
            OPC_JUMP: m_jump = 1'b1;
            default:  ;
        endcase
    end

    // ALU control: class and funct to operation
    always_comb begin
        op    = ALU_ADD;
        fn_ok = 1'b1;
        case (cls)
            CLS_ADDR: op = ALU_ADD;
            CLS_CMP:  op = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
                if (shamt != '0)
                    fn_ok = 1'b0;
            end
            default: op = ALU_ADD;
        endcase
    end

    assign ctrl.reg_write   = m_reg_wr & fn_ok;
    assign ctrl.dst_is_rd   = m_dst_rd;
    assign ctrl.b_is_imm    = m_b_imm;
    assign ctrl.wb_from_mem = m_from_mem;
    assign ctrl.mem_write   = m_mem_wr;
    assign ctrl.branch      = m_branch;
    assign ctrl.jump        = m_jump;
    assign ctrl.alu_op      = op;
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// Single-cycle subset processor core. Fetch, decode with register read,
// ALU, data memory access and write-back all complete in the cycle that
// fetches the instruction; the PC and all stores update at the rising edge.
// Assumes word-aligned accesses; addresses wrap modulo each memory's size.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int PRE_AW = ($clog2(IMEM_WORDS) > $clog2(DMEM_WORDS)) ?
                           $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic              pre_dmem,
    input  logic [PRE_AW-1:0] pre_addr,
    input  logic [XLEN-1:0]   pre_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              wb_en,
    output logic [REG_AW-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              st_en,
    output logic [XLEN-1:0]   st_addr,
    output logic [XLEN-1:0]   st_data
);
    localparam int IAW   = $clog2(IMEM_WORDS);
    localparam int DAW   = $clog2(DMEM_WORDS);
    localparam int NREGS = 1 << REG_AW;

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0]   instr, imm_sext, rs_val, rt_val, alu_b, alu_y, dmem_q;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd, dst;
    logic              alu_zero;
    ctrl_t             ctrl;

    // ---------------- fetch ----------------
    sc_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk      (clk),
        .pre_we   (pre_we & ~pre_dmem),
        .pre_idx  (pre_addr[IAW-1:0]),
        .pre_data (pre_data),
        .wr_en    (1'b0),
        .wr_idx   ('0),
        .wr_data  ('0),
        .rd_idx   (pc_q[IAW+1:2]),
        .rd_data  (instr)
    );

    // ---------------- decode and register read ----------------
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .shamt  (instr[10:6]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_en),
        .waddr (dst),
        .wdata (wb_data),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    // ---------------- execute ----------------
    assign alu_b = ctrl.b_is_imm ? imm_sext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---------------- memory ----------------
    sc_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk      (clk),
        .pre_we   (pre_we & pre_dmem),
        .pre_idx  (pre_addr[DAW-1:0]),
        .pre_data (pre_data),
        .wr_en    (ctrl.mem_write & rst_n),
        .wr_idx   (alu_y[DAW+1:2]),
        .wr_data  (rt_val),
        .rd_idx   (alu_y[DAW+1:2]),
        .rd_data  (dmem_q)
    );

    // ---------------- write-back ----------------
    assign dst     = ctrl.dst_is_rd ? f_rd : f_rt;
    assign wb_en   = ctrl.reg_write && (dst != '0);
    assign wb_idx  = dst;
    assign wb_data = ctrl.wb_from_mem ? dmem_q : alu_y;

    assign st_en   = ctrl.mem_write;
    assign st_addr = alu_y;
    assign st_data = rt_val;

    // ---------------- next PC ----------------
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

    // Choose among sequential, branch and jump successors
    always_comb begin
        if (ctrl.jump)
            pc_next = jmp_target;
        else if (ctrl.branch && alu_zero)
            pc_next = br_target;
        else
            pc_next = pc_plus4;
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
// Port-level assertions for sc_core, attached with bind below.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_o,
    input logic        wb_en,
    input logic [4:0]  wb_idx,
    input logic        st_en
);
    // R1
    pc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_o == 32'd0));

    // R6
    no_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != 5'd0));

    // R5
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> !wb_en);

    // R3
    wb_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (pc_o == $past(pc_o) + 32'd4));

    // R5
    store_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> (pc_o == $past(pc_o) + 32'd4));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_o   (pc_o),
    .wb_en  (wb_en),
    .wb_idx (wb_idx),
    .st_en  (st_en)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
// Scoreboard bench: an instruction-level model predicts each cycle's
// observation bus entries into a queue; a monitor compares them at negedges.
module sc_core_test;
    localparam int  ITEMS_PER_RUN = 40;
    localparam int  WDOG_CYCLES   = 20000;
    localparam real HALF          = 4.0;

    localparam logic [5:0] O_REG = 6'h00, O_J = 6'h02, O_BEQ = 6'h04,
                           O_LW = 6'h23, O_SW = 6'h2B;
    localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24,
                           F_OR = 6'h25, F_SLT = 6'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_we = 1'b0;
    logic        pre_dmem = 1'b0;
    logic [5:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [31:0] pc_o, wb_data, st_addr, st_data;
    logic        wb_en, st_en;
    logic [4:0]  wb_idx;

    sc_core uut (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_dmem(pre_dmem),
        .pre_addr(pre_addr), .pre_data(pre_data), .pc_o(pc_o),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
    );

    always #(HALF) clk = ~clk;

    typedef struct {
        logic [31:0] pc;
        logic        wb;
        logic [4:0]  idx;
        logic [31:0] wd;
        logic        st;
        logic [31:0] sa;
        logic [31:0] sd;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          fails  = 0;
    logic        mon_on = 1'b0;
    logic        done   = 1'b0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_imem [64];
    logic [31:0] m_dmem [64];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd,
                                          logic [4:0] rs, logic [4:0] rt);
        return {O_REG, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Preload one word through the port and mirror it in the model
    task automatic preload(input logic sel, input int idx, input logic [31:0] val);
        @(negedge clk);
        pre_we   = 1'b1;
        pre_dmem = sel;
        pre_addr = 6'(idx);
        pre_data = val;
        @(negedge clk);
        pre_we = 1'b0;
        if (sel) m_dmem[idx] = val;
        else     m_imem[idx] = val;
    endtask

    // Driver: step the model one instruction and push the expectation
    task automatic predict_one(input bool_first);
        exp_t        e;
        logic [31:0] w, a, b, simm, npc, res, addr;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, sh;
        logic        ok;
        w    = m_imem[m_pc[7:2]];
        op   = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
        sh   = w[10:6];  fn = w[5:0];
        simm = {{16{w[15]}}, w[15:0]};
        a    = m_reg[rs]; b = m_reg[rt];
        npc  = m_pc + 32'd4;
        e.pc = m_pc; e.wb = 1'b0; e.idx = '0; e.wd = '0;
        e.st = 1'b0; e.sa = '0; e.sd = '0; e.req = "R9";
        case (op)
            O_REG: begin
                ok  = (sh == 5'd0);
                res = '0;
                case (fn)
                    F_ADD:   res = a + b;
                    F_SUB:   res = a - b;
                    F_AND:   res = a & b;
                    F_OR:    res = a | b;
                    F_SLT:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: ok = 1'b0;
                endcase
                if (ok) begin
                    e.req = (rd == 5'd0) ? "R6" : "R3";
                    if (rd != 5'd0) begin
                        e.wb = 1'b1; e.idx = rd; e.wd = res; m_reg[rd] = res;
                    end
                end
            end
            O_LW: begin
                addr  = a + simm;
                e.req = (rt == 5'd0) ? "R6" : "R4 R10";
                if (rt != 5'd0) begin
                    e.wb = 1'b1; e.idx = rt; e.wd = m_dmem[addr[7:2]];
                    m_reg[rt] = e.wd;
                end
            end
            O_SW: begin
                addr  = a + simm;
                e.req = "R5";
                e.st = 1'b1; e.sa = addr; e.sd = b;
                m_dmem[addr[7:2]] = b;
            end
            O_BEQ: begin
                e.req = "R7";
                if (a == b) npc = npc + {simm[29:0], 2'b00};
            end
            O_J: begin
                e.req = "R8 R11";
                npc = {npc[31:28], w[25:0], 2'b00};
            end
            default: e.req = "R9";
        endcase
        if (bool_first) e.req = {"R1 ", e.req};
        m_pc = npc;
        sb_q.push_back(e);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;
    endtask

    // Hold reset, check the PC is cleared, then predict and run one pass
    task automatic run_pass();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pc_o !== 32'd0) begin
            fails++;
            $display("FAIL R1 pc in reset: actual %h expected %h", pc_o, 32'd0);
        end
        model_reset();
        for (int i = 0; i < ITEMS_PER_RUN; i++) predict_one(i == 0);
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_on = 1'b1;
        wait (sb_q.size() == 0);
        @(posedge clk);
        #1;
        mon_on = 1'b0;
    endtask

    // Monitor: compare the observation buses with the next expectation
    always @(negedge clk) begin
        if (mon_on && sb_q.size() > 0) begin
            exp_t e;
            logic bad;
            e   = sb_q.pop_front();
            bad = (pc_o !== e.pc) || (wb_en !== e.wb) || (st_en !== e.st);
            if (e.wb && ((wb_idx !== e.idx) || (wb_data !== e.wd))) bad = 1'b1;
            if (e.st && ((st_addr !== e.sa) || (st_data !== e.sd))) bad = 1'b1;
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL R2 %s: actual pc=%h wb=%b/%0d/%h st=%b/%h/%h expected pc=%h wb=%b/%0d/%h st=%b/%h/%h",
                         e.req, pc_o, wb_en, wb_idx, wb_data, st_en, st_addr, st_data,
                         e.pc, e.wb, e.idx, e.wd, e.st, e.sa, e.sd);
            end
        end
    end

    initial begin
        logic [31:0] prog [29];
        prog[0]  = enc_r(F_OR, 5'd16, 5'd3, 5'd4);      // reads regs cleared by R1
        prog[1]  = enc_i(O_LW, 5'd0, 5'd1, 16'd0);
        prog[2]  = enc_i(O_LW, 5'd0, 5'd2, 16'd4);
        prog[3]  = enc_r(F_ADD, 5'd3, 5'd1, 5'd2);
        prog[4]  = enc_r(F_SUB, 5'd4, 5'd1, 5'd2);
        prog[5]  = enc_r(F_AND, 5'd5, 5'd3, 5'd2);
        prog[6]  = enc_r(F_OR,  5'd6, 5'd3, 5'd2);
        prog[7]  = enc_r(F_SLT, 5'd7, 5'd4, 5'd1);
        prog[8]  = enc_r(F_SLT, 5'd8, 5'd1, 5'd4);
        prog[9]  = enc_r(F_ADD, 5'd0, 5'd1, 5'd2);      // R6 discarded write
        prog[10] = enc_r(F_ADD, 5'd9, 5'd0, 5'd0);      // R6 reads zero
        prog[11] = enc_i(O_SW, 5'd0, 5'd3, 16'd16);
        prog[12] = enc_i(O_LW, 5'd3, 5'd10, 16'hFFFC);  // negative offset
        prog[13] = enc_i(O_BEQ, 5'd1, 5'd2, 16'd5);     // not taken
        prog[14] = enc_i(O_BEQ, 5'd1, 5'd1, 16'd2);     // forward taken
        prog[15] = enc_r(F_ADD, 5'd11, 5'd1, 5'd1);
        prog[16] = enc_r(F_ADD, 5'd11, 5'd2, 5'd2);
        prog[17] = enc_r(F_ADD, 5'd12, 5'd12, 5'd1);
        prog[18] = enc_i(O_BEQ, 5'd12, 5'd6, 16'd1);
        prog[19] = enc_i(O_BEQ, 5'd0, 5'd0, 16'hFFFD);  // backward
        prog[20] = enc_i(O_LW, 5'd0, 5'd13, 16'd16);
        prog[21] = enc_i(O_SW, 5'd0, 5'd3, 16'd112);    // R11 data word 28
        prog[22] = {O_J, 26'd24};
        prog[23] = enc_r(F_ADD, 5'd14, 5'd1, 5'd1);
        prog[24] = {O_REG, 5'd1, 5'd2, 5'd15, 5'd1, F_ADD}; // R9 shamt set
        prog[25] = {O_REG, 5'd1, 5'd2, 5'd15, 5'd0, 6'h00}; // R9 bad funct
        prog[26] = {6'h3F, 5'd1, 5'd2, 5'd15, 11'd0};       // R9 bad opcode
        prog[27] = enc_i(O_LW, 5'd0, 5'd15, 16'd112);
        prog[28] = {O_J, 26'd28};                           // halt, R11 target

        for (int i = 0; i < 64; i++) begin
            m_imem[i] = '0;
            m_dmem[i] = '0;
        end
        model_reset();
        for (int i = 0; i < 64; i++) preload(1'b0, i, (i < 29) ? prog[i] : 32'd0);
        preload(1'b1, 0, 32'd5);
        preload(1'b1, 1, 32'd7);
        preload(1'b1, 2, 32'hFFFF_FFF0);
        preload(1'b1, 3, 32'h1234_5678);

        run_pass();
        run_pass();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(WDOG_CYCLES * 2 * HALF);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule